// File: doc/BRIEF.md
# Voltage-Frequency Change Sequencer

This block moves a processor core between four fixed operating points. Each point pairs a core clock with a supply voltage. A request names the target point and is launched by a one-cycle start strobe. The sequencer then sets the regulator code and the PLL controls in an order that keeps the core safe at every step. When the clock speeds up, the voltage rises first and the clock follows. When the clock slows down, the clock drops first and the voltage follows. Each time the PLL is retuned, it is first parked in bypass. The new divider is written, bypass is released, and the block waits until the clock-divider busy flag goes low.

The four points, from fastest to slowest, are: 600 MHz core / 150 MHz bus at 1.275 V, 528 MHz / 132 MHz at 1.15 V, 132 MHz / 66 MHz at 1.15 V, and 24 MHz / 12 MHz at 0.95 V. At the slowest point the PLL is switched off and the core runs from the internal RC oscillator. A busy/done pair tells the caller when the change has finished. The regulator and the PLL lie outside the block. They answer through a voltage-good input and a divider-busy input.

Top module: `dvfs_step_seq`

## Requirements
- R1: When the target point is faster than the current one and the voltages differ, the voltage code changes before any PLL divider or oscillator-select output changes.
- R2: When the target point is slower than the current one and the voltages differ, the divider or oscillator select changes before the voltage code changes.
- R3: A retune to a PLL-driven point runs in this order: bypass and PLL enable go high, the divider is written while bypass stays high, bypass is released, and the block then waits until the divider-busy input is low.
- R4: Target encoding is 0=600 MHz, 1=528 MHz, 2=132 MHz, 3=24 MHz. When a change completes, the voltage code is (millivolts − 800)/25, giving 19, 14, 14 and 6. The divider is core MHz/12, giving 50, 44 and 11. The bus ratio is core/bus, giving 4, 4, 2 and 2.
- R5: At point 3 the oscillator select is 1, PLL enable is 0 and bypass is 1, and the divider keeps its previous value. Leaving point 3 returns the oscillator select to 0 and the enable to 1.
- R6: A start whose target equals the current point produces a done pulse one cycle after the strobe. Busy stays low and no other output changes.
- R7: Between points 1 and 2, which share a voltage, the voltage step and its wait are skipped and the voltage code never changes.
- R8: Busy is high without a gap from the cycle after an accepted start until the final wait ends. It falls in the same cycle that done pulses for one cycle. A start while busy is ignored.
- R9: After writing the voltage code, the block lets one cycle pass and then holds until voltage-good is high. A change therefore takes (D_v+3 if the voltage changes) + D_p + 5 busy cycles. D_v and D_p are the regulator and divider settle delays, measured from the responder's first edge.
- R10: After reset the outputs hold point 0: voltage code 19, divider 50, ratio 4, bypass 0, enable 1, oscillator select 0, busy 0, done 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe |
| target | input | 2 | Requested operating point index |
| vgood | input | 1 | Regulator output is at the requested level |
| div_busy | input | 1 | Clock-divider handshake still in progress |
| busy | output | 1 | A change is in progress |
| done | output | 1 | One-cycle completion pulse |
| vsel | output | VW | Regulator voltage code |
| pll_div | output | DW | PLL loop divider |
| bus_ratio | output | RW | Core-to-bus clock ratio |
| pll_bypass | output | 1 | PLL output bypassed to the reference |
| pll_en | output | 1 | PLL powered |
| osc_rc_sel | output | 1 | Core clock taken from the RC oscillator |

## Verification
The assertions rely on the regulator pulling voltage-good low no later than one cycle after the voltage code changes. They also rely on the PLL responder raising divider-busy as soon as the divider or oscillator select moves. The bench's behavioural responders do both: each compares the live output with the last value it latched and holds its flag for a programmable settle delay. The ordering checks assume a new start comes only when the block is idle, except for the deliberate strobes that test whether a request is ignored. Start strobes are driven on falling edges so that each one is seen by exactly one rising edge.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  localparam int NUM_PT = 4;
  localparam int PT_W   = 2;
  localparam int LOW_PT = 3;

  typedef enum logic [3:0] {
    S_IDLE,
    S_V_SET,
    S_V_ARM,
    S_V_WAIT,
    S_F_BYP,
    S_F_DIV,
    S_F_REL,
    S_F_WAIT,
    S_DONE
  } seq_st_e;

  function automatic int pt_core_mhz(input int p);
    case (p)
      0:       return 600;
      1:       return 528;
      2:       return 132;
      default: return 24;
    endcase
  endfunction

  function automatic int pt_bus_mhz(input int p);
    case (p)
      0:       return 150;
      1:       return 132;
      2:       return 66;
      default: return 12;
    endcase
  endfunction

  function automatic int pt_mv(input int p);
    case (p)
      0:       return 1275;
      1:       return 1150;
      2:       return 1150;
      default: return 950;
    endcase
  endfunction
endpackage

// File: rtl/dvfs_optable.sv
module dvfs_optable
  import dvfs_pkg::*;
#(
  parameter int VW      = 6,
  parameter int DW      = 7,
  parameter int RW      = 3,
  parameter int MV_BASE = 800,
  parameter int MV_STEP = 25,
  parameter int REF_MHZ = 12
) (
  input  logic [PT_W-1:0] pt,
  output logic [VW-1:0]   vcode,
  output logic [DW-1:0]   div,
  output logic [RW-1:0]   ratio,
  output logic            is_rc
);
  logic [VW-1:0] vtab [NUM_PT];
  logic [DW-1:0] dtab [NUM_PT];
  logic [RW-1:0] rtab [NUM_PT];
  logic [NUM_PT-1:0] rctab;

  for (genvar g = 0; g < NUM_PT; g++) begin : g_pt
    localparam int VC = (pt_mv(g) - MV_BASE) / MV_STEP;
    localparam int DV = pt_core_mhz(g) / REF_MHZ;
    localparam int RT = pt_core_mhz(g) / pt_bus_mhz(g);
    assign vtab[g]  = VW'(VC);
    assign dtab[g]  = DW'(DV);
    assign rtab[g]  = RW'(RT);
    assign rctab[g] = (g == LOW_PT);
  end

  assign vcode = vtab[pt];
  assign div   = dtab[pt];
  assign ratio = rtab[pt];
  assign is_rc = rctab[pt];
endmodule

// File: rtl/dvfs_clk_regs.sv
module dvfs_clk_regs #(
  parameter int VW        = 6,
  parameter int DW        = 7,
  parameter int RW        = 3,
  parameter int RST_V     = 19,
  parameter int RST_DIV   = 50,
  parameter int RST_RATIO = 4,
  parameter bit RST_RC    = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_load,
  input  logic          byp_set,
  input  logic          div_load,
  input  logic          rc_load,
  input  logic          byp_clr,
  input  logic [VW-1:0] v_new,
  input  logic [DW-1:0] div_new,
  input  logic [RW-1:0] ratio_new,
  output logic [VW-1:0] vsel,
  output logic [DW-1:0] pll_div,
  output logic [RW-1:0] bus_ratio,
  output logic          pll_bypass,
  output logic          pll_en,
  output logic          osc_rc_sel
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vsel       <= VW'(RST_V);
      pll_div    <= DW'(RST_DIV);
      bus_ratio  <= RW'(RST_RATIO);
      pll_bypass <= RST_RC;
      pll_en     <= !RST_RC;
      osc_rc_sel <= RST_RC;
    end else begin
      if (v_load) vsel <= v_new;
      if (byp_set) begin
        pll_bypass <= 1'b1;
        pll_en     <= 1'b1;
      end
      if (div_load) begin
        pll_div    <= div_new;
        bus_ratio  <= ratio_new;
        osc_rc_sel <= 1'b0;
      end
      if (rc_load) begin
        bus_ratio  <= ratio_new;
        osc_rc_sel <= 1'b1;
        pll_en     <= 1'b0;
      end
      if (byp_clr) pll_bypass <= 1'b0;
    end
  end
endmodule

// File: rtl/dvfs_seq_ctrl.sv
module dvfs_seq_ctrl
  import dvfs_pkg::*;
#(
  parameter int VW       = 6,
  parameter int RESET_PT = 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [PT_W-1:0] target,
  input  logic            vgood,
  input  logic            div_busy,
  input  logic [VW-1:0]   nxt_vcode,
  input  logic [VW-1:0]   vsel,
  input  logic            nxt_is_rc,
  output logic [PT_W-1:0] lookup_pt,
  output logic            v_load,
  output logic            byp_set,
  output logic            div_load,
  output logic            rc_load,
  output logic            byp_clr,
  output logic            busy,
  output logic            done
);
  seq_st_e         st;
  logic [PT_W-1:0] cur_pt;
  logic [PT_W-1:0] tgt_pt;
  logic            up_q;
  logic            vsame_q;
  logic            go_up;
  logic            vsame;

  assign lookup_pt = (st == S_IDLE) ? target : tgt_pt;
  assign go_up     = (target < cur_pt);
  assign vsame     = (nxt_vcode == vsel);

  assign v_load   = (st == S_V_SET);
  assign byp_set  = (st == S_F_BYP);
  assign div_load = (st == S_F_DIV) && !nxt_is_rc;
  assign rc_load  = (st == S_F_DIV) && nxt_is_rc;
  assign byp_clr  = (st == S_F_REL);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      cur_pt  <= PT_W'(RESET_PT);
      tgt_pt  <= PT_W'(RESET_PT);
      up_q    <= 1'b0;
      vsame_q <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            if (target == cur_pt) begin
              done <= 1'b1;
            end else begin
              tgt_pt  <= target;
              up_q    <= go_up;
              vsame_q <= vsame;
              busy    <= 1'b1;
              st      <= (go_up && !vsame) ? S_V_SET : S_F_BYP;
            end
          end
        end
        S_V_SET: st <= S_V_ARM;
        S_V_ARM: st <= S_V_WAIT;
        S_V_WAIT: begin
          if (vgood) st <= up_q ? S_F_BYP : S_DONE;
        end
        S_F_BYP: st <= S_F_DIV;
        S_F_DIV: st <= nxt_is_rc ? S_F_WAIT : S_F_REL;
        S_F_REL: st <= S_F_WAIT;
        S_F_WAIT: begin
          if (!div_busy) st <= (up_q || vsame_q) ? S_DONE : S_V_SET;
        end
        S_DONE: begin
          busy   <= 1'b0;
          done   <= 1'b1;
          cur_pt <= tgt_pt;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dvfs_step_seq.sv
module dvfs_step_seq
  import dvfs_pkg::*;
#(
  parameter int VW       = 6,
  parameter int DW       = 7,
  parameter int RW       = 3,
  parameter int MV_BASE  = 800,
  parameter int MV_STEP  = 25,
  parameter int REF_MHZ  = 12,
  parameter int RESET_PT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [1:0]    target,
  input  logic          vgood,
  input  logic          div_busy,
  output logic          busy,
  output logic          done,
  output logic [VW-1:0] vsel,
  output logic [DW-1:0] pll_div,
  output logic [RW-1:0] bus_ratio,
  output logic          pll_bypass,
  output logic          pll_en,
  output logic          osc_rc_sel
);
  localparam int RST_V     = (pt_mv(RESET_PT) - MV_BASE) / MV_STEP;
  localparam int RST_DIV   = pt_core_mhz(RESET_PT) / REF_MHZ;
  localparam int RST_RATIO = pt_core_mhz(RESET_PT) / pt_bus_mhz(RESET_PT);
  localparam bit RST_RC    = (RESET_PT == LOW_PT);

  logic [PT_W-1:0] lookup_pt;
  logic [VW-1:0]   nxt_vcode;
  logic [DW-1:0]   nxt_div;
  logic [RW-1:0]   nxt_ratio;
  logic            nxt_is_rc;
  logic            v_load, byp_set, div_load, rc_load, byp_clr;

  dvfs_optable #(
    .VW(VW), .DW(DW), .RW(RW),
    .MV_BASE(MV_BASE), .MV_STEP(MV_STEP), .REF_MHZ(REF_MHZ)
  ) u_table (
    .pt(lookup_pt), .vcode(nxt_vcode), .div(nxt_div),
    .ratio(nxt_ratio), .is_rc(nxt_is_rc)
  );

  dvfs_seq_ctrl #(.VW(VW), .RESET_PT(RESET_PT)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .target(target),
    .vgood(vgood), .div_busy(div_busy),
    .nxt_vcode(nxt_vcode), .vsel(vsel), .nxt_is_rc(nxt_is_rc),
    .lookup_pt(lookup_pt), .v_load(v_load), .byp_set(byp_set),
    .div_load(div_load), .rc_load(rc_load), .byp_clr(byp_clr),
    .busy(busy), .done(done)
  );

  dvfs_clk_regs #(
    .VW(VW), .DW(DW), .RW(RW),
    .RST_V(RST_V), .RST_DIV(RST_DIV), .RST_RATIO(RST_RATIO), .RST_RC(RST_RC)
  ) u_regs (
    .clk(clk), .rst(rst),
    .v_load(v_load), .byp_set(byp_set), .div_load(div_load),
    .rc_load(rc_load), .byp_clr(byp_clr),
    .v_new(nxt_vcode), .div_new(nxt_div), .ratio_new(nxt_ratio),
    .vsel(vsel), .pll_div(pll_div), .bus_ratio(bus_ratio),
    .pll_bypass(pll_bypass), .pll_en(pll_en), .osc_rc_sel(osc_rc_sel)
  );
endmodule

// File: rtl/dvfs_step_seq_chk.sv
module dvfs_step_seq_chk #(
  parameter int VW = 6,
  parameter int DW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [VW-1:0] vsel,
  input logic [DW-1:0] pll_div,
  input logic          pll_bypass,
  input logic          pll_en,
  input logic          osc_rc_sel
);
  logic byp_q;
  logic ftouch;

  always_ff @(posedge clk) begin
    if (rst) begin
      byp_q  <= 1'b0;
      ftouch <= 1'b0;
    end else begin
      byp_q <= pll_bypass;
      if (start && !busy) ftouch <= 1'b0;
      else if (pll_bypass && !byp_q) ftouch <= 1'b1;
    end
  end

  p_raise_volt_first_r1: assert property (@(posedge clk) disable iff (rst)
    (vsel > $past(vsel)) |-> !ftouch);

  p_lower_volt_last_r2: assert property (@(posedge clk) disable iff (rst)
    (vsel < $past(vsel)) |-> ftouch);

  p_div_under_bypass_r3: assert property (@(posedge clk) disable iff (rst)
    (pll_div != $past(pll_div)) |-> (pll_bypass && $past(pll_bypass) && pll_en));

  p_rc_bypassed_r5: assert property (@(posedge clk) disable iff (rst)
    osc_rc_sel |-> pll_bypass);

  p_rc_pll_off_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (osc_rc_sel && !busy) |-> !pll_en);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  p_busy_ends_done_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done || $past(start));
endmodule

bind dvfs_step_seq dvfs_step_seq_chk #(.VW(VW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .vsel(vsel), .pll_div(pll_div), .pll_bypass(pll_bypass),
  .pll_en(pll_en), .osc_rc_sel(osc_rc_sel)
);

// File: tb/tb_dvfs_step_seq.sv
`timescale 1ns/1ps
module tb_dvfs_step_seq;
  localparam int VW = 6;
  localparam int DW = 7;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] target = 2'd0;
  logic vgood, div_busy;
  logic busy, done;
  logic [VW-1:0] vsel;
  logic [DW-1:0] pll_div;
  logic [RW-1:0] bus_ratio;
  logic pll_bypass, pll_en, osc_rc_sel;

  int checks = 0;
  int fails  = 0;
  int rdly   = 0;
  int pdly   = 0;
  int cur    = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dvfs_step_seq dut (
    .clk(clk), .rst(rst), .start(start), .target(target),
    .vgood(vgood), .div_busy(div_busy), .busy(busy), .done(done),
    .vsel(vsel), .pll_div(pll_div), .bus_ratio(bus_ratio),
    .pll_bypass(pll_bypass), .pll_en(pll_en), .osc_rc_sel(osc_rc_sel)
  );

  // behavioural regulator and PLL responders
  logic [VW-1:0] vapp;
  logic [DW-1:0] dapp;
  logic rapp;
  int rcnt, pcnt;
  always @(posedge clk) begin
    if (rst) begin
      vapp <= vsel; dapp <= pll_div; rapp <= osc_rc_sel; rcnt <= 0; pcnt <= 0;
    end else begin
      if (vsel != vapp) begin vapp <= vsel; rcnt <= rdly; end
      else if (rcnt != 0) rcnt <= rcnt - 1;
      if (pll_div != dapp || osc_rc_sel != rapp) begin
        dapp <= pll_div; rapp <= osc_rc_sel; pcnt <= pdly;
      end else if (pcnt != 0) pcnt <= pcnt - 1;
    end
  end
  assign vgood    = (vsel == vapp) && (rcnt == 0);
  assign div_busy = (pll_div != dapp) || (osc_rc_sel != rapp) || (pcnt != 0);

  function automatic int e_mv(input int p);
    case (p) 0: return 1275; 1: return 1150; 2: return 1150; default: return 950; endcase
  endfunction
  function automatic int e_core(input int p);
    case (p) 0: return 600; 1: return 528; 2: return 132; default: return 24; endcase
  endfunction
  function automatic int e_bus(input int p);
    case (p) 0: return 150; 1: return 132; 2: return 66; default: return 12; endcase
  endfunction
  function automatic int e_v(input int p);   return (e_mv(p) - 800) / 25; endfunction
  function automatic int e_div(input int p); return e_core(p) / 12; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic do_move(input int t, input bit inj);
    int from = cur;
    int k = 0, busy_n = 0, gaps = 0, vch = -1, fch = -1, brise = -1, bfall = -1;
    int exp_busy;
    bit byp_at_f = 1'b0, en_at_f = 1'b0, vdiff, up;
    logic [VW-1:0] pv; logic [DW-1:0] pd; logic pr, pb, pe; logic [RW-1:0] prt;
    @(negedge clk);
    pv = vsel; pd = pll_div; pr = osc_rc_sel; pb = pll_bypass; pe = pll_en; prt = bus_ratio;
    target = 2'(t); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) begin
      if (busy) busy_n++; else gaps++;
      if (vsel != pv && vch < 0) vch = k;
      if ((pll_div != pd || osc_rc_sel != pr) && fch < 0) begin
        fch = k; byp_at_f = pll_bypass; en_at_f = pll_en;
      end
      if (pll_bypass && !pb && brise < 0) brise = k;
      if (!pll_bypass && pb) bfall = k;
      pv = vsel; pd = pll_div; pr = osc_rc_sel; pb = pll_bypass;
      if (inj && k == 2) begin start = 1'b1; target = 2'((t + 1) % 4); end
      if (k == 3) start = 1'b0;
      k++;
      @(negedge clk);
    end
    vdiff = (e_v(from) != e_v(t));
    up    = (t < from);
    if (t == from) begin
      chk(k == 0, "R6", k, 0);
      chk(busy_n == 0 && !busy, "R6", busy_n, 0);
      chk(vsel == pv && pll_div == pd && osc_rc_sel == pr && pll_bypass == pb
          && pll_en == pe && bus_ratio == prt, "R6", 0, 1);
    end else begin
      exp_busy = (vdiff ? rdly + 3 : 0) + pdly + 5;
      chk(busy_n == exp_busy, "R9", busy_n, exp_busy);
      chk(gaps == 0 && !busy, "R8", gaps, 0);
      if (vdiff && up)  chk(vch >= 0 && fch > vch, "R1", vch, fch);
      if (vdiff && !up) chk(fch >= 0 && vch > fch, "R2", vch, fch);
      if (!vdiff)       chk(vch < 0, "R7", vch, -1);
      chk(byp_at_f && fch >= 0, "R3", int'(byp_at_f), 1);
      if (t != 3) begin
        chk(en_at_f, "R3", int'(en_at_f), 1);
        if (from != 3) chk(brise >= 0 && brise < fch, "R3", brise, fch);
        chk(bfall > fch && !pll_bypass, "R3", bfall, fch + 1);
        chk(int'(pll_div) == e_div(t), "R4", int'(pll_div), e_div(t));
      end
      chk(int'(vsel) == e_v(t), "R4", int'(vsel), e_v(t));
      chk(int'(bus_ratio) == e_core(t) / e_bus(t), "R4", int'(bus_ratio), e_core(t) / e_bus(t));
      if (t == 3)
        chk(osc_rc_sel && !pll_en && pll_bypass && pll_div == pd, "R5", int'(osc_rc_sel), 1);
      else
        chk(!osc_rc_sel && pll_en, "R5", int'(osc_rc_sel), 0);
      if (inj) chk(int'(vsel) == e_v(t) && osc_rc_sel == (t == 3), "R8", int'(vsel), e_v(t));
    end
    @(negedge clk);
    chk(!done, "R8", int'(done), 0);
    cur = t;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(vsel == 6'd19 && pll_div == 7'd50 && bus_ratio == 3'd4, "R10", int'(vsel), 19);
    chk(!pll_bypass && pll_en && !osc_rc_sel && !busy && !done, "R10", int'(pll_bypass), 0);
    cur = 0;
    for (int s = 0; s < 2; s++) begin
      rdly = (s == 0) ? 0 : 3;
      pdly = (s == 0) ? 0 : 5;
      for (int f = 0; f < 4; f++) begin
        for (int t = 0; t < 4; t++) begin
          if (cur != f) do_move(f, 1'b0);
          do_move(t, (t != f) && (s == 1) && (t % 2 == 0));
        end
      end
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule